// File: doc/BRIEF.md
# Shared-Multiplier Eight-Tap FIR Filter

This block is an eight-tap transversal FIR filter built around one signed 16x16 multiplier and a single accumulator. It takes in one signed sample per filter cycle. The multiplier then works through the taps one per clock: the newest sample comes straight from the input port, and the older samples and the coefficients come from two stores that rotate as rings. Each store returns to its starting order by the end of the filter cycle.

A filter cycle starts on the clock that accepts a sample. That clock computes tap 0, and the remaining taps follow on consecutive clocks. The full-precision sum is then placed in an output register with a one-clock valid pulse. Before filtering starts, coefficients are written through a simple addressed write port while the filter is idle. The accumulator wraps in two's complement. It does not round or saturate.

Top module: `fir_tdm_mac`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_data is 0. All stored samples and all coefficients are cleared to zero, so a sample sent before any coefficient write gives a result of 0.
- R2: in_ready is 1 only while the filter is idle. After the clock that accepts a sample (in_valid and in_ready both 1), in_ready stays 0 for exactly TAPS-1 clocks.
- R3: out_valid goes high for exactly one clock. It rises on the rising edge TAPS-1 edges after the edge that accepted the sample.
- R4: The result for sample u(k) is the sum over i = 0..TAPS-1 of a_i times u(k-i), taken as a signed 32-bit two's-complement value. Samples that were never supplied since reset count as zero.
- R5: Each product keeps its full signed 32-bit width. For example, -32768 times -32768 gives 0x40000000. The running sum wraps modulo 2^32.
- R6: A coefficient write at coef_addr = i sets a_i. Address 0 multiplies the newest sample and address TAPS-1 multiplies the oldest.
- R7: A coefficient write is taken only on an idle clock in which no sample is being accepted. On any other clock it is ignored, and every coefficient is unchanged for later results.
- R8: in_valid pulses while in_ready is 0 are ignored. No sample enters the history and no extra filter cycle runs.
- R9: out_data holds its value from one out_valid pulse to the next.
- R10: Idle gaps of any length between samples, with any value on in_data while in_valid is 0, leave the stored history and later results unaffected.
- R11: If in_valid is held at 1, the filter accepts a new sample on the same clock that out_valid is high. This gives one result every TAPS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index (tap number) |
| coef_data | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Filter idle, able to take a sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | 32 | Signed filter result, held between pulses |

## Verification
If a ring position is out of step, whether a missed rotation, a rotation in the wrong direction or a write that lands during a busy cycle, products are paired with the wrong coefficient. An impulse then shows this within the next result pulse, TAPS clocks later, as a coefficient appearing in the wrong position or duplicated. A sequencer count that is off shifts the pulse position or the in_ready window, which is visible on the very next sample. A fault in the history shift stays hidden until the affected sample reaches a nonzero tap, so the bench uses varied coefficients and samples followed by long zero runs.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int unsigned FIR_DATA_W = 16;
    localparam int unsigned FIR_TAPS   = 8;
    localparam int unsigned FIR_ACC_W  = 2 * FIR_DATA_W;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-clock control word broadcast by the sequencer
    typedef struct packed {
        logic step;   // a tap is processed this clock
        logic first;  // tap 0: sample accepted, accumulator restarts
        logic last;   // final tap: result goes to the output register
    } tap_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/fir_seq.sv
module fir_seq
    import fir_pkg::*;
#(
    parameter int unsigned TAPS = FIR_TAPS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    output tap_ctl_t ctl
);
    localparam int unsigned CNT_W = cnt_width(TAPS);
    localparam logic [CNT_W-1:0] LAST_TAP = CNT_W'(TAPS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] tap_q;

    always_comb begin
        in_ready  = (state_q == SEQ_IDLE);
        ctl.first = in_valid && (state_q == SEQ_IDLE);
        ctl.step  = ctl.first || (state_q == SEQ_RUN);
        ctl.last  = (state_q == SEQ_RUN) && (tap_q == LAST_TAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tap_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (ctl.first) begin
                        state_q <= SEQ_RUN;
                        tap_q   <= CNT_W'(1);
                    end
                end
                SEQ_RUN: begin
                    if (tap_q == LAST_TAP) begin
                        state_q <= SEQ_IDLE;
                        tap_q   <= '0;
                    end else begin
                        tap_q <= tap_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    tap_q   <= '0;
                end
            endcase
        end
    end

    // Checker: length of each busy stretch
    logic [CNT_W:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (rst)           busy_run_q <= '0;
        else if (in_ready) busy_run_q <= '0;
        else               busy_run_q <= busy_run_q + 1'b1;
    end

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready)
        else $error("sequencer still ready after accepting a sample");

    p_busy_span_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (busy_run_q == (CNT_W+1)'(TAPS - 1)))
        else $error("busy window length differs from TAPS-1");

endmodule

// File: rtl/fir_sample_ring.sv
module fir_sample_ring
    import fir_pkg::*;
#(
    parameter int unsigned DATA_W = FIR_DATA_W,
    parameter int unsigned TAPS   = FIR_TAPS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tap_first,
    input  logic                     tap_step,
    input  logic signed [DATA_W-1:0] in_data,
    output logic signed [DATA_W-1:0] x_out
);
    localparam int unsigned HIST = TAPS - 1;

    // cur_q: newest sample; hist_q[0] = next older, hist_q[HIST-1] = oldest kept
    logic signed [DATA_W-1:0] cur_q;
    logic signed [DATA_W-1:0] hist_q [HIST];

    always_ff @(posedge clk) begin
        if (rst)            cur_q <= '0;
        else if (tap_first) cur_q <= in_data;
    end

    for (genvar i = 0; i < HIST; i++) begin : g_hist
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)            hist_q[i] <= '0;
                else if (tap_first) hist_q[i] <= cur_q;
                else if (tap_step)  hist_q[i] <= hist_q[(i + 1) % HIST];
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)            hist_q[i] <= '0;
                else if (tap_first) hist_q[i] <= hist_q[i - 1];
                else if (tap_step)  hist_q[i] <= hist_q[(i + 1) % HIST];
            end
        end
    end

    // Tap 0 multiplies the arriving sample, later taps read the ring head
    assign x_out = tap_first ? in_data : hist_q[0];

    p_first_has_step_r10: assert property (@(posedge clk) disable iff (rst)
        (!tap_step) |=> $stable(cur_q))
        else $error("newest sample changed on an idle clock");

endmodule

// File: rtl/fir_coef_ring.sv
module fir_coef_ring
    import fir_pkg::*;
#(
    parameter int unsigned DATA_W = FIR_DATA_W,
    parameter int unsigned TAPS   = FIR_TAPS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  tap_ctl_t                  ctl,
    input  logic                      idle,
    input  logic                      wr_en,
    input  logic [$clog2(TAPS)-1:0]   wr_addr,
    input  logic signed [DATA_W-1:0]  wr_data,
    output logic signed [DATA_W-1:0]  c_out
);
    localparam int unsigned ADDR_W = $clog2(TAPS);
    localparam int unsigned FLAT_W = TAPS * DATA_W;

    logic signed [DATA_W-1:0] coef_q [TAPS];
    logic                     wr_ok;

    assign wr_ok = idle && wr_en && !ctl.first;

    for (genvar i = 0; i < TAPS; i++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst)
                coef_q[i] <= '0;
            else if (wr_ok && (wr_addr == ADDR_W'(i)))
                coef_q[i] <= wr_data;
            else if (ctl.step)
                coef_q[i] <= coef_q[(i + 1) % TAPS];
        end
    end

    assign c_out = coef_q[0];

    // Checker: the ring must be back in home order after a full filter cycle
    logic [FLAT_W-1:0] ring_flat;
    logic [FLAT_W-1:0] snap_q;

    always_comb begin
        for (int i = 0; i < TAPS; i++) begin
            ring_flat[i*DATA_W +: DATA_W] = coef_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            snap_q <= '0;
        else if (ctl.first) snap_q <= ring_flat;
    end

    p_ring_home_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.last |=> (ring_flat == snap_q))
        else $error("coefficient ring not restored after filter cycle");

endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_pkg::*;
#(
    parameter int unsigned DATA_W = FIR_DATA_W,
    parameter int unsigned ACC_W  = FIR_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tap_ctl_t                 ctl,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] c_in,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_data
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  sum;

    always_comb begin
        prod     = x_in * c_in;
        prod_ext = ACC_W'($signed(prod));
        sum      = ctl.first ? prod_ext : (acc_q + prod_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (ctl.step) acc_q <= sum;
            out_valid <= ctl.last;
            if (ctl.last) out_data <= sum;
        end
    end

    p_pulse_one_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("result pulse longer than one clock");

    p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
        (!out_valid) |-> $stable(out_data))
        else $error("result changed without a pulse");

endmodule

// File: rtl/fir_tdm_mac.sv
module fir_tdm_mac
    import fir_pkg::*;
#(
    parameter int unsigned DATA_W = FIR_DATA_W,
    parameter int unsigned TAPS   = FIR_TAPS,
    parameter int unsigned ACC_W  = FIR_ACC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_addr,
    input  logic signed [DATA_W-1:0]  coef_data,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic signed [ACC_W-1:0]   out_data
);
    tap_ctl_t                 ctl;
    logic signed [DATA_W-1:0] x_op;
    logic signed [DATA_W-1:0] c_op;

    fir_seq #(
        .TAPS (TAPS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .ctl      (ctl)
    );

    fir_sample_ring #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_samples (
        .clk       (clk),
        .rst       (rst),
        .tap_first (ctl.first),
        .tap_step  (ctl.step),
        .in_data   (in_data),
        .x_out     (x_op)
    );

    fir_coef_ring #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_coefs (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .idle    (in_ready),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .c_out   (c_op)
    );

    fir_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .x_in      (x_op),
        .c_in      (c_op),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    p_last_gives_result_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.last |=> out_valid)
        else $error("final tap not followed by a result pulse");

    p_ready_with_result_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready)
        else $error("filter busy while presenting a result");

endmodule

// File: tb/tb_fir_tdm_mac.sv
module tb_fir_tdm_mac;

    logic               clk = 1'b0;
    logic               rst;
    logic               coef_we;
    logic [2:0]         coef_addr;
    logic signed [15:0] coef_data;
    logic               in_valid;
    logic signed [15:0] in_data;
    logic               in_ready;
    logic               out_valid;
    logic signed [31:0] out_data;

    always #10 clk = ~clk;

    fir_tdm_mac dut (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic signed [15:0] cm [8];
    logic signed [15:0] hm [8];

    // Stimulus vectors: sample value and idle gap after the result
    localparam logic [15:0] TV_S [12] = '{
        16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1357, 16'hC0DE,
        16'h0000, 16'h2468, 16'h8001, 16'h0F0F, 16'hFFFE, 16'h4000};
    localparam int TV_G [12] = '{0, 3, 1, 0, 7, 2, 0, 5, 1, 0, 4, 9};

    localparam logic [15:0] CO [8] = '{
        16'h1234, 16'hF00D, 16'h0007, 16'h7FFF,
        16'h8000, 16'hFFFF, 16'h0100, 16'h0055};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_out();
        longint acc = 0;
        for (int i = 0; i < 8; i++) acc += longint'(cm[i]) * longint'(hm[i]);
        return acc[31:0];
    endfunction

    task automatic model_push(input logic signed [15:0] s);
        for (int i = 7; i > 0; i--) hm[i] = hm[i-1];
        hm[0] = s;
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        coef_we = 1'b0; coef_addr = '0; coef_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin cm[i] = '0; hm[i] = '0; end
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic write_coef(input int idx, input logic [15:0] v);
        wait_idle();
        coef_we = 1'b1; coef_addr = idx[2:0]; coef_data = v;
        @(negedge clk);
        coef_we = 1'b0; coef_data = 16'h5A5A;
        cm[idx] = v;
    endtask

    // Sends one sample; the result pulse is expected 8 negedges after setup
    // (accepting edge plus 7 more edges, R3). Checks R2, R3, R4.
    task automatic send(input logic [15:0] s, output logic [31:0] got);
        int lat;
        wait_idle();
        in_valid = 1'b1; in_data = s;
        @(negedge clk);
        in_valid = 1'b0; in_data = 16'hBEEF;
        lat = 1;
        chk("R2 busy after accept", {31'd0, in_ready}, 32'd0);
        while (!out_valid && lat < 40) begin @(negedge clk); lat++; end
        chk("R3 result latency", lat, 32'd8);
        model_push(s);
        got = out_data;
        chk("R4 filter sum", got, model_out());
        chk("R2 ready with result", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        chk("R3 one-clock pulse", {31'd0, out_valid}, 32'd0);
    endtask

    logic [31:0] got;
    logic [31:0] prev;

    initial begin
        do_reset();
        chk("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
        chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset out_data", out_data, 32'd0);

        send(16'h1111, got);
        chk("R1 cleared coefficients", got, 32'd0);

        do_reset();
        for (int i = 0; i < 8; i++) write_coef(i, CO[i]);

        // R6 impulse: result n equals a_n
        send(16'h0001, got);
        chk("R6 address 0 is newest tap", got, {{16{CO[0][15]}}, CO[0]});
        for (int n = 1; n < 8; n++) begin
            send(16'h0000, got);
            chk("R6 impulse tap order", got, {{16{CO[n][15]}}, CO[n]});
        end
        send(16'h0000, got);
        chk("R6 impulse gone", got, 32'd0);

        // R4/R10 table walk with idle gaps and junk on in_data
        for (int v = 0; v < 12; v++) begin
            send(TV_S[v], got);
            in_data = 16'h7A7A ^ 16'(v);
            repeat (TV_G[v]) @(negedge clk);
            chk("R9 result held", out_data, got);
            chk("R10 idle stays idle", {31'd0, in_ready}, 32'd1);
        end

        // R8: in_valid pulse while busy is ignored
        wait_idle();
        in_valid = 1'b1; in_data = 16'h0321;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h7777;
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        model_push(16'h0321);
        chk("R8 result without busy sample", out_data, model_out());
        @(negedge clk);
        send(16'h0002, got);
        chk("R8 history without busy sample", got, model_out());

        // R7: coefficient write while busy is ignored
        wait_idle();
        in_valid = 1'b1; in_data = 16'h0040;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 3'd0; coef_data = 16'h7FFF;
        @(negedge clk);
        coef_we = 1'b0;
        while (!out_valid) @(negedge clk);
        model_push(16'h0040);
        chk("R7 busy write ignored now", out_data, model_out());
        @(negedge clk);
        send(16'h0003, got);
        chk("R7 busy write ignored later", got, model_out());

        // R11: back-to-back with in_valid held high
        wait_idle();
        for (int n = 0; n < 6; n++) begin
            int gap;
            in_valid = 1'b1; in_data = 16'(16'h0101 * (n + 1)) ^ 16'h8000;
            model_push(in_data);
            prev = model_out();
            gap = 0;
            do begin @(negedge clk); gap++; end while (!in_ready && gap < 20);
            chk("R11 period", gap, 32'd8);
            chk("R11 pulse with ready", {31'd0, out_valid}, 32'd1);
            chk("R11 sum", out_data, prev);
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R5: full product and wrap
        do_reset();
        for (int i = 0; i < 8; i++) write_coef(i, 16'h8000);
        send(16'h8000, got);
        chk("R5 full product", got, 32'h4000_0000);
        send(16'h8000, got);
        chk("R5 wrap to negative", got, 32'h8000_0000);
        send(16'h8000, got);
        send(16'h8000, got);
        chk("R5 wrap to zero", got, 32'h0000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule